// File: doc/BRIEF.md
# Host Bridge Control Registers

This block is the software-visible register file of a PCI host bridge. It holds twelve 64-bit window registers: four window bases, four window masks and four translated bases. It also holds one 64-bit bridge control word. A host port issues single-beat read and write requests, each carrying an address and a byte count. The block works out a register index from the offset of the address from its base, with one register every 64 bytes. It returns the read data, or an error flag, one cycle later.

All twelve window registers and the control word are driven out in parallel, so that a separate address translation unit can use them without going through the request port. A few indices read as zero. Of those, some accept writes and discard them, and one refuses writes. A write to the invalidate-all index produces a one-cycle flush strobe for a downstream translation cache. Indices for error-set, latency, monitoring, single-entry invalidate, the reserved slot, and all undefined offsets answer with an error.

Top module: `hbr_regs`

## Requirements
- R1: The register index is (req_addr − BASE_ADDR) >> 6, computed modulo 2^AW. The low six address bits do not select a register. The map is: 0–3 window base, 4–7 window mask, 8–11 translated base, 12 control, 13 latency, 14 reserved, 15 error status, 16 error mask, 17 error set, 18 single invalidate, 19 invalidate all, 20 monitor control, 21 monitor count. An address below the base wraps to a large index and is undefined.
- R2: Only req_size = 8 (a byte count) is legal. Any other size returns resp_err = 1 and changes no register.
- R3: The twelve window registers reset to zero, and a legal write followed by a read returns the written 64-bit value.
- R4: The control register resets to 64'h0000_0021_0010_0000: bit 20 set, bit 32 set, and the value 2 in the field starting at bit 36. It is fully writable afterwards.
- R5: The error status index reads as zero without error. A write to it gets resp_err = 0 and changes nothing.
- R6: The error mask index reads as zero without error. A write to it gets resp_err = 1.
- R7: The invalidate-all index reads as zero. A legal write to it gets resp_err = 0 and raises flush_o for exactly the cycle of its response. flush_o is low at all other times.
- R8: Indices 13, 14, 17, 18, 20, 21 and every index of 22 or more answer with resp_err = 1, for reads and for writes, and change no register.
- R9: Each request accepted with req_valid gets exactly one resp_valid, in the next cycle. rdata is zero for writes and for errored responses.
- R10: win_base_o, win_mask_o, xlat_base_o and ctl_o show a written value from the cycle of the write's response. A read issued in that same cycle already returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address of the request |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response present (one cycle after request) |
| resp_err | output | 1 | Response is an error |
| rdata | output | 64 | Read data |
| win_base_o | output | 4x64 | Window base registers |
| win_mask_o | output | 4x64 | Window mask registers |
| xlat_base_o | output | 4x64 | Translated base registers |
| ctl_o | output | 64 | Control register |
| flush_o | output | 1 | One-cycle strobe on a write to invalidate-all |

## Verification
A register update and a read of that same register can fall in the same cycle. The write's response cycle is also the cycle in which a following request is decoded, so the read that trails a write must see the new contents. The bench provokes this by keeping req_valid high across a write and an immediately following read of the same index. It judges the result by comparing the read's rdata, one cycle later, with the value its model stored on the write. The flush strobe is judged in the same way against the invalidate-all write's response cycle.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam int REG_W    = 64;
  localparam int NWIN     = 4;
  localparam int NREG     = 3 * NWIN;
  localparam int SLOT_W   = $clog2(NREG);
  localparam int STRIDE_LG = 6;
  localparam int NUM_IDX  = 22;
  localparam int LEGAL_SIZE = 8;

  localparam int IDX_CTL     = NREG;
  localparam int IDX_ERRSTAT = 15;
  localparam int IDX_ERRMASK = 16;
  localparam int IDX_INVALL  = 19;

  localparam logic [REG_W-1:0] CTL_RST =
    (64'd1 << 20) | (64'd1 << 32) | (64'd2 << 36);

  typedef enum logic [2:0] {
    K_WIN, K_CTL, K_RAZ_WI, K_RAZ_WERR, K_INVALL, K_BAD
  } kind_t;

  // Classify an in-range index into its access behaviour.
  function automatic kind_t classify(input logic [4:0] i);
    if (int'(i) < NREG)              return K_WIN;
    else if (int'(i) == IDX_CTL)     return K_CTL;
    else if (int'(i) == IDX_ERRSTAT) return K_RAZ_WI;
    else if (int'(i) == IDX_ERRMASK) return K_RAZ_WERR;
    else if (int'(i) == IDX_INVALL)  return K_INVALL;
    else                             return K_BAD;
  endfunction
endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
  import hbr_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] BASE_ADDR = 32'h0001_0000
)(
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [3:0]        req_size,
  output kind_t             kind,
  output logic [SLOT_W-1:0] slot,
  output logic              dec_err,
  output logic [NREG-1:0]   wr_win,
  output logic              wr_ctl,
  output logic              wr_flush
);
  logic [AW-1:0] offs;
  logic [AW-1:0] idx;
  logic          in_range;
  logic          size_ok;
  logic          do_wr;

  always_comb begin
    offs     = req_addr - BASE_ADDR;
    idx      = offs >> STRIDE_LG;
    in_range = (idx < AW'(NUM_IDX));
    size_ok  = (req_size == 4'(LEGAL_SIZE));
    kind     = in_range ? classify(idx[4:0]) : K_BAD;
    slot     = idx[SLOT_W-1:0];
    dec_err  = !size_ok || (kind == K_BAD) || (req_write && kind == K_RAZ_WERR);
    do_wr    = req_valid && req_write && !dec_err;
    wr_win   = '0;
    if (do_wr && kind == K_WIN) wr_win[slot] = 1'b1;
    wr_ctl   = do_wr && (kind == K_CTL);
    wr_flush = do_wr && (kind == K_INVALL);
  end
endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
  import hbr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREG-1:0]            wr_win,
  input  logic                       wr_ctl,
  input  logic [REG_W-1:0]           wdata,
  output logic [NREG-1:0][REG_W-1:0] win_q,
  output logic [REG_W-1:0]           ctl_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n)         win_q[g] <= '0;
      else if (wr_win[g]) win_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (wr_ctl) ctl_q <= wdata;
  end
endmodule

// File: rtl/hbr_resp.sv
module hbr_resp
  import hbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             dec_err,
  input  logic             wr_flush,
  input  logic [REG_W-1:0] rd_val,
  output logic             resp_valid,
  output logic             resp_err,
  output logic [REG_W-1:0] rdata,
  output logic             flush_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      rdata      <= '0;
      flush_o    <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= req_valid && dec_err;
      rdata      <= (req_valid && !req_write && !dec_err) ? rd_val : '0;
      flush_o    <= wr_flush;
    end
  end
endmodule

// File: rtl/hbr_regs.sv
module hbr_regs
  import hbr_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] BASE_ADDR = 32'h0001_0000
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [AW-1:0]              req_addr,
  input  logic [3:0]                 req_size,
  input  logic [63:0]                req_wdata,
  output logic                       resp_valid,
  output logic                       resp_err,
  output logic [63:0]                rdata,
  output logic [3:0][63:0]           win_base_o,
  output logic [3:0][63:0]           win_mask_o,
  output logic [3:0][63:0]           xlat_base_o,
  output logic [63:0]                ctl_o,
  output logic                       flush_o
);
  kind_t                      kind;
  logic [SLOT_W-1:0]          slot;
  logic                       dec_err;
  logic [NREG-1:0]            wr_win;
  logic                       wr_ctl;
  logic                       wr_flush;
  logic [NREG-1:0][REG_W-1:0] win_q;
  logic [REG_W-1:0]           rd_val;

  hbr_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .kind(kind), .slot(slot), .dec_err(dec_err),
    .wr_win(wr_win), .wr_ctl(wr_ctl), .wr_flush(wr_flush)
  );

  hbr_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .wr_win(wr_win), .wr_ctl(wr_ctl),
    .wdata(req_wdata), .win_q(win_q), .ctl_q(ctl_o)
  );

  always_comb begin
    case (kind)
      K_WIN:   rd_val = win_q[slot];
      K_CTL:   rd_val = ctl_o;
      default: rd_val = '0;
    endcase
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_out
    assign win_base_o[g]  = win_q[g];
    assign win_mask_o[g]  = win_q[NWIN + g];
    assign xlat_base_o[g] = win_q[2*NWIN + g];
  end

  hbr_resp u_resp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .dec_err(dec_err), .wr_flush(wr_flush), .rd_val(rd_val),
    .resp_valid(resp_valid), .resp_err(resp_err), .rdata(rdata),
    .flush_o(flush_o)
  );
endmodule

// File: rtl/hbr_regs_chk.sv
module hbr_regs_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [3:0]      req_size,
  input logic            dec_err,
  input logic            resp_valid,
  input logic            resp_err,
  input logic [63:0]     rdata,
  input logic [3:0][63:0] win_base_o,
  input logic [63:0]     ctl_o,
  input logic            flush_o
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid); // R9
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid); // R9
  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> (rdata == 64'd0)); // R9
  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 4'd8) |=> resp_err); // R2
  AST_BAD_SIZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 4'd8) |=> ($stable(ctl_o) && $stable(win_base_o))); // R2
  AST_DECODE_ERR_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dec_err) |=> (resp_valid && resp_err)); // R8
  AST_FLUSH_OK_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (resp_valid && !resp_err)); // R7
endmodule

bind hbr_regs hbr_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
  .dec_err(dec_err), .resp_valid(resp_valid), .resp_err(resp_err),
  .rdata(rdata), .win_base_o(win_base_o), .ctl_o(ctl_o), .flush_o(flush_o)
);

// File: tb/hbr_regs_tb.sv
`timescale 1ns/1ps
module hbr_regs_tb;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [63:0] CTL_EXP = 64'h0000_0021_0010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic resp_valid, resp_err, flush_o;
  logic [63:0] rdata, ctl_o;
  logic [3:0][63:0] win_base_o, win_mask_o, xlat_base_o;

  always #2.5 clk = ~clk;

  hbr_regs #(.AW(32), .BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .rdata(rdata),
    .win_base_o(win_base_o), .win_mask_o(win_mask_o), .xlat_base_o(xlat_base_o),
    .ctl_o(ctl_o), .flush_o(flush_o)
  );

  int checks = 0, failures = 0;
  logic [63:0] m_win [12];
  logic [63:0] m_ctl;
  bit pend = 0, pe_err = 0, pe_fl = 0;
  logic [63:0] pe_rd = '0;
  string pe_tag = "";

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: 0=win,1=ctl,2=raz ignore wr,3=raz err wr,4=inv-all,5=bad
  function automatic int kind_of(input logic [31:0] a);
    logic [31:0] d = (a - BASE) >> 6;
    if (d <= 11) return 0;
    if (d == 12) return 1;
    if (d == 15) return 2;
    if (d == 16) return 3;
    if (d == 19) return 4;
    return 5;
  endfunction

  task automatic cycle(input bit v, input bit w, input logic [31:0] a,
                       input logic [3:0] sz, input logic [63:0] d, input string tag);
    @(negedge clk);
    if (pend) begin
      chk({63'd0, resp_valid}, 64'd1, {pe_tag, " resp_valid"});
      chk({63'd0, resp_err}, {63'd0, pe_err}, {pe_tag, " resp_err"});
      chk(rdata, pe_rd, {pe_tag, " rdata"});
      chk({63'd0, flush_o}, {63'd0, pe_fl}, {pe_tag, " R7 flush"});
    end else begin
      chk({62'd0, resp_valid, flush_o}, 64'd0, "R9 idle R7 no flush");
    end
    for (int i = 0; i < 4; i++) begin
      chk(win_base_o[i], m_win[i], "R10 win_base_o");
      chk(win_mask_o[i], m_win[4+i], "R10 win_mask_o");
      chk(xlat_base_o[i], m_win[8+i], "R10 xlat_base_o");
    end
    chk(ctl_o, m_ctl, "R10 ctl_o");
    req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    pend = v; pe_tag = tag; pe_fl = 0; pe_rd = '0;
    if (v) begin
      int k = kind_of(a);
      pe_err = (sz != 4'd8) || (k == 5) || (w && k == 3);
      if (!pe_err && !w) begin
        if (k == 0) pe_rd = m_win[((a - BASE) >> 6)];
        else if (k == 1) pe_rd = m_ctl;
      end
      if (!pe_err && w) begin
        if (k == 0) m_win[((a - BASE) >> 6)] = d;
        else if (k == 1) m_ctl = d;
        else if (k == 4) pe_fl = 1;
      end
    end
  endtask

  function automatic logic [31:0] ad(input int idx, input int low);
    return BASE + 32'(idx * 64) + 32'(low);
  endfunction

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 12; i++) m_win[i] = '0;
    m_ctl = CTL_EXP;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state R3 R4 (checked inside cycle against model)
    cycle(0, 0, 0, 0, 0, "R3");
    chk(ctl_o, CTL_EXP, "R4 reset value");
    cycle(1, 0, ad(12, 0), 8, 0, "R4 read ctl");
    cycle(1, 1, ad(12, 5), 8, 64'hDEAD_BEEF_0123_4567, "R4 write ctl");
    cycle(1, 0, ad(12, 63), 8, 0, "R4 R1 readback");
    cycle(1, 1, ad(2, 17), 8, 64'h1111_2222_3333_4444, "R3 R1 write base2");
    cycle(1, 0, ad(2, 0), 8, 0, "R3 read base2");
    cycle(1, 1, ad(12, 0), 4, 64'h5, "R2 size4");
    cycle(1, 1, ad(7, 0), 1, 64'h5, "R2 size1");
    cycle(1, 0, ad(7, 0), 2, 0, "R2 size2 read");
    cycle(1, 1, ad(15, 0), 8, 64'hFFFF, "R5 write errstat");
    cycle(1, 0, ad(15, 0), 8, 0, "R5 read errstat");
    cycle(1, 0, ad(16, 0), 8, 0, "R6 read errmask");
    cycle(1, 1, ad(16, 0), 8, 64'h1, "R6 write errmask");
    cycle(1, 1, ad(19, 0), 8, 64'hABC, "R7 invall write");
    cycle(1, 0, ad(19, 0), 8, 0, "R7 invall read");
    cycle(1, 1, ad(13, 0), 8, 64'h7, "R8 latency write");
    cycle(1, 0, ad(21, 0), 8, 0, "R8 moncnt read");
    cycle(1, 0, ad(40, 0), 8, 0, "R8 undefined");
    cycle(1, 1, BASE - 32'd64, 8, 64'h9, "R8 R1 below base");
    // back-to-back write then read of same register R10
    cycle(1, 1, ad(9, 0), 8, 64'hCAFE_F00D_0000_0009, "R10 b2b write");
    cycle(1, 0, ad(9, 0), 8, 0, "R10 b2b read");
    cycle(1, 1, ad(19, 0), 8, 0, "R7 b2b flush");
    cycle(1, 0, ad(19, 0), 8, 0, "R7 flush once");
    cycle(0, 0, 0, 0, 0, "R9");
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 7);
      logic [3:0] sz = (r == 0) ? 4'd1 : (r == 1) ? 4'd2 : (r == 2) ? 4'd4 : 4'd8;
      cycle($urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1,
            ad($urandom_range(0, 25), $urandom_range(0, 63)), sz,
            {$urandom, $urandom}, "R9 random");
    end
    cycle(0, 0, 0, 0, 0, "R9");
    cycle(0, 0, 0, 0, 0, "R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule